// File: doc/BRIEF.md
# Programmable DMA Cycle Timing Sequencer

This block runs a single DMA write transfer toward a memory card as three back-to-back phases: setup, command and recovery. It starts a transfer once the DMA request and the DMA acknowledge are both high while it is idle. During the command phase it pulls an active-low read strobe low. If the card holds its active-low wait line low when the command count is used up, the block stretches the strobe. When the system terminal count was high at the start of the transfer, the block also gives the card a shorter, active-low output-enable pulse nested inside the strobe window.

Each phase length comes from a timing byte. The two upper bits of the byte pick a prescale factor, and the six lower bits hold a multiplier. There are two banks of three timing bytes, and a select input chooses the bank for each transfer. The bytes and the bank choice are captured when the transfer starts, so a write made during a transfer only takes effect on later transfers. The block pulses a done flag in the final recovery clock.

Top module: `dma_cycle_sequencer`

## Requirements
- R1: After a synchronous active-low reset the block is idle. `busy` and `cycle_done` are low, and `rd_stb_n` and `oe_n` are high.
- R2: A transfer starts at a clock edge only when `dma_req` and `dma_ack` are both high and the block is idle. Either signal alone leaves the block idle.
- R3: A phase length in clocks is prescale × value + 1. Bits [5:0] of the timing byte hold the value. Bits [7:6] pick the prescale: 00 gives 1, 01 gives 16, 10 gives 68 and 11 gives 2048.
- R4: After reset, bank 0 holds setup 01h, command 06h and recovery 03h, which give 2, 7 and 4 clocks. Bank 1 holds 00h in all three bytes, which gives 1 clock per phase.
- R5: A transfer keeps `busy` high with `rd_stb_n` high for S clocks. `rd_stb_n` is then low for C clocks, and `busy` stays high with `rd_stb_n` high for R more clocks. `cycle_done` is high in exactly the last of those R clocks, and `busy` is low in the clock after it.
- R6: If `card_wait_n` is sampled low at the end of the final command clock, the command phase is held. Once `card_wait_n` is sampled high, `rd_stb_n` stays low for exactly 2 more clocks. A low `card_wait_n` that is released before the final command clock has no effect.
- R7: When `sys_tc` is high at the start edge, `oe_n` is low during command clocks 2 to C−1, which is max(C−2, 0) clocks. This never includes the first or the last strobe clock, and wait stretching does not change it. When `sys_tc` is low at the start edge, `oe_n` stays high.
- R8: `tmr_sel` picks the bank at the start edge. A write with `cfg_we` high stores `cfg_wdata` into bank `cfg_set`: `cfg_phase` 0 selects setup, 1 selects command and 2 selects recovery, and 3 is ignored. A write never changes a transfer that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dma_req | input | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge |
| sys_tc | input | 1 | System terminal count, sampled at the start edge |
| card_wait_n | input | 1 | Card wait, active low |
| tmr_sel | input | 1 | Bank select for the next transfer |
| cfg_we | input | 1 | Timing byte write enable |
| cfg_set | input | 1 | Bank written |
| cfg_phase | input | 2 | Phase byte written (0 setup, 1 command, 2 recovery) |
| cfg_wdata | input | 8 | Timing byte value |
| rd_stb_n | output | 1 | Read strobe to the card, active low |
| oe_n | output | 1 | Terminal-count output enable to the card, active low |
| busy | output | 1 | Transfer in progress |
| cycle_done | output | 1 | One-clock pulse in the last recovery clock |

## Verification
A wrong phase counter or a wrong captured length shows up in the same transfer as a strobe or phase that is too long or too short. It also shows up as a `cycle_done` pulse in the wrong clock. The first such error appears as soon as the faulty phase ends. A wrong stretch flag adds or drops the two trailing strobe clocks, and a wrong terminal-count capture adds or removes the whole output-enable pulse. An error in the timing banks shows up only on the next transfer that uses the affected bank.

// File: rtl/dma_seq_pkg.sv
// Shared types and the phase-length function for the DMA cycle sequencer.
// Assumes 8-bit timing bytes: [7:6] prescale code, [5:0] multiplier.
package dma_seq_pkg;
    localparam int TREG_W = 8;
    localparam int LEN_W  = 17;   // 2048*63+1 fits in 17 bits

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CMD,
        PH_TAIL,
        PH_REC
    } phase_e;

    typedef struct packed {
        logic [TREG_W-1:0] setup;
        logic [TREG_W-1:0] cmd;
        logic [TREG_W-1:0] rec;
    } tbank_t;

    typedef struct packed {
        logic [LEN_W-1:0] s;
        logic [LEN_W-1:0] c;
        logic [LEN_W-1:0] r;
    } tlen_t;

    // Phase length in clocks = prescale * value + 1.
    function automatic logic [LEN_W-1:0] phase_len(input logic [TREG_W-1:0] t);
        logic [LEN_W-1:0] pre;
        case (t[7:6])
            2'd0:    pre = LEN_W'(1);
            2'd1:    pre = LEN_W'(16);
            2'd2:    pre = LEN_W'(68);
            default: pre = LEN_W'(2048);
        endcase
        return pre * LEN_W'(t[5:0]) + LEN_W'(1);
    endfunction
endpackage

// File: rtl/dma_timing_regs.sv
// Timing banks: NUM_SETS banks of setup/command/recovery bytes.
// Bank 0 resets to 01h/06h/03h, and the other banks reset to zero.
// Assumes the selected bank is used only at the start of a transfer.
module dma_timing_regs
    import dma_seq_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int SEL_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_set,
    input  logic [1:0]        cfg_phase,
    input  logic [TREG_W-1:0] cfg_wdata,
    input  logic [SEL_W-1:0]  tmr_sel,
    output tbank_t            sel_bank
);
    localparam tbank_t BANK0_RST = '{setup: 8'h01, cmd: 8'h06, rec: 8'h03};

    tbank_t banks [NUM_SETS];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_bank
        localparam tbank_t RST_VAL = (g == 0) ? BANK0_RST : '0;
        // Store one timing byte of this bank on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                banks[g] <= RST_VAL;
            end else if (cfg_we && cfg_set == SEL_W'(g)) begin
                case (cfg_phase)
                    2'd0:    banks[g].setup <= cfg_wdata;
                    2'd1:    banks[g].cmd   <= cfg_wdata;
                    2'd2:    banks[g].rec   <= cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Route the bank picked by tmr_sel to the sequencer.
    always_comb begin
        sel_bank = banks[0];
        for (int i = 0; i < NUM_SETS; i++) begin
            if (tmr_sel == SEL_W'(i)) sel_bank = banks[i];
        end
    end
endmodule

// File: rtl/dma_phase_fsm.sv
// Phase sequencer: captures the three lengths and terminal count at start,
// steps setup -> command (+ optional wait tail) -> recovery -> idle.
// Assumes TAIL_CLKS >= 1 and that start is only honoured while idle.
module dma_phase_fsm
    import dma_seq_pkg::*;
#(
    parameter int TAIL_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sys_tc,
    input  logic             card_wait_n,
    input  tbank_t           bank,
    output phase_e           phase,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] cmd_len,
    output logic             tc_q,
    output logic             last_rec
);
    tlen_t len_q;
    logic  stretched;

    // Advance the phase and its clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            len_q     <= '0;
            tc_q      <= 1'b0;
            stretched <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase     <= PH_SETUP;
                        cnt       <= LEN_W'(1);
                        len_q.s   <= phase_len(bank.setup);
                        len_q.c   <= phase_len(bank.cmd);
                        len_q.r   <= phase_len(bank.rec);
                        tc_q      <= sys_tc;
                        stretched <= 1'b0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == len_q.s) begin
                        phase <= PH_CMD;
                        cnt   <= LEN_W'(1);
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                PH_CMD: begin
                    if (cnt != len_q.c) begin
                        cnt <= cnt + LEN_W'(1);
                    end else if (!card_wait_n) begin
                        stretched <= 1'b1;
                    end else begin
                        phase <= stretched ? PH_TAIL : PH_REC;
                        cnt   <= LEN_W'(1);
                    end
                end
                PH_TAIL: begin
                    if (cnt == LEN_W'(TAIL_CLKS)) begin
                        phase <= PH_REC;
                        cnt   <= LEN_W'(1);
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                PH_REC: begin
                    if (cnt == len_q.r) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Expose the captured command length and flag the final recovery clock.
    always_comb begin
        cmd_len  = len_q.c;
        last_rec = (phase == PH_REC) && (cnt == len_q.r);
    end
endmodule

// File: rtl/dma_strobe_decode.sv
// Output decode: derives the card strobes and status from phase state.
// Assumes all inputs come straight from registers, so outputs are clean.
module dma_strobe_decode
    import dma_seq_pkg::*;
(
    input  phase_e           phase,
    input  logic [LEN_W-1:0] cnt,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             tc_q,
    input  logic             last_rec,
    output logic             rd_stb_n,
    output logic             oe_n,
    output logic             busy,
    output logic             cycle_done
);
    // Strobe low through command and tail; OE nested inside clocks 2..C-1.
    always_comb begin
        rd_stb_n   = !((phase == PH_CMD) || (phase == PH_TAIL));
        oe_n       = !(tc_q && (phase == PH_CMD) &&
                       (cnt >= LEN_W'(2)) && (cnt < cmd_len));
        busy       = (phase != PH_IDLE);
        cycle_done = last_rec;
    end
endmodule

// File: rtl/dma_cycle_sequencer.sv
// Top of the DMA cycle sequencer: timing banks, phase sequencer, decode.
// Assumes dma_req/dma_ack and the config inputs are synchronous to clk.
module dma_cycle_sequencer
    import dma_seq_pkg::*;
#(
    parameter int NUM_SETS  = 2,
    parameter int TAIL_CLKS = 2,
    localparam int SEL_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_req,
    input  logic              dma_ack,
    input  logic              sys_tc,
    input  logic              card_wait_n,
    input  logic [SEL_W-1:0]  tmr_sel,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_set,
    input  logic [1:0]        cfg_phase,
    input  logic [TREG_W-1:0] cfg_wdata,
    output logic              rd_stb_n,
    output logic              oe_n,
    output logic              busy,
    output logic              cycle_done
);
    tbank_t           bank;
    phase_e           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cmd_len;
    logic             tc_q;
    logic             last_rec;
    logic             start;

    // A transfer request needs both handshake lines.
    always_comb start = dma_req && dma_ack;

    dma_timing_regs #(.NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_set   (cfg_set),
        .cfg_phase (cfg_phase),
        .cfg_wdata (cfg_wdata),
        .tmr_sel   (tmr_sel),
        .sel_bank  (bank)
    );

    dma_phase_fsm #(.TAIL_CLKS(TAIL_CLKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .sys_tc      (sys_tc),
        .card_wait_n (card_wait_n),
        .bank        (bank),
        .phase       (phase),
        .cnt         (cnt),
        .cmd_len     (cmd_len),
        .tc_q        (tc_q),
        .last_rec    (last_rec)
    );

    dma_strobe_decode u_dec (
        .phase      (phase),
        .cnt        (cnt),
        .cmd_len    (cmd_len),
        .tc_q       (tc_q),
        .last_rec   (last_rec),
        .rd_stb_n   (rd_stb_n),
        .oe_n       (oe_n),
        .busy       (busy),
        .cycle_done (cycle_done)
    );
endmodule

// File: rtl/dma_seq_checker.sv
// Port-level protocol checks for the DMA cycle sequencer, bound to the top.
module dma_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic dma_req,
    input logic dma_ack,
    input logic rd_stb_n,
    input logic oe_n,
    input logic busy,
    input logic cycle_done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_stb_n && oe_n && !cycle_done));

    p_start_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && dma_req && dma_ack) |=> busy);

    p_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(dma_req && dma_ack)) |=> !busy);

    p_setup_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_stb_n) |-> (busy && $past(busy)));

    p_done_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (!busy && !cycle_done));

    p_oe_nested_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !rd_stb_n);

    p_oe_not_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_stb_n) |-> oe_n);

    p_oe_not_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_stb_n) |-> $past(oe_n));
endmodule

bind dma_cycle_sequencer dma_seq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dma_req    (dma_req),
    .dma_ack    (dma_ack),
    .rd_stb_n   (rd_stb_n),
    .oe_n       (oe_n),
    .busy       (busy),
    .cycle_done (cycle_done)
);

// File: tb/tb_dma_cycle_sequencer.sv
`timescale 1ns/1ps
module tb_dma_cycle_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_req = 1'b0, dma_ack = 1'b0, sys_tc = 1'b0;
    logic       card_wait_n = 1'b1, tmr_sel = 1'b0;
    logic       cfg_we = 1'b0, cfg_set = 1'b0;
    logic [1:0] cfg_phase = 2'd0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       rd_stb_n, oe_n, busy, cycle_done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dma_cycle_sequencer dut (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .dma_ack(dma_ack),
        .sys_tc(sys_tc), .card_wait_n(card_wait_n), .tmr_sel(tmr_sel),
        .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_phase(cfg_phase),
        .cfg_wdata(cfg_wdata), .rd_stb_n(rd_stb_n), .oe_n(oe_n),
        .busy(busy), .cycle_done(cycle_done)
    );

    typedef struct packed {
        logic        bank;
        logic        tc;
        int unsigned k;     // strobe clocks before wait release, 0 = no wait
        int unsigned s;
        int unsigned w;
        int unsigned r;
        int unsigned oe;
    } vec_t;

    // Bank 0 at reset: 2/7/4. Bank 1 programmed to 02h/41h/81h: 3/17/69.
    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 0,  2, 7,  4,  0},
        '{1'b0, 1'b1, 0,  2, 7,  4,  5},
        '{1'b0, 1'b0, 10, 2, 12, 4,  0},
        '{1'b0, 1'b1, 10, 2, 12, 4,  5},
        '{1'b0, 1'b0, 7,  2, 7,  4,  0},
        '{1'b1, 1'b0, 0,  3, 17, 69, 0},
        '{1'b1, 1'b1, 20, 3, 22, 69, 15},
        '{1'b1, 1'b1, 5,  3, 17, 69, 15}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic bnk, input logic [1:0] ph, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_set = bnk; cfg_phase = ph; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Run one transfer and check the phase widths it shows at the ports.
    task automatic run_cycle(input logic bnk, input logic tc, input int k,
                             input bit midwr, input int es, input int ew,
                             input int er, input int eo, input string req);
        int pre = 0, rdw = 0, post = 0, oew = 0, donec = 0, guard = 0;
        bit seen_rd = 0, started = 0;
        @(negedge clk);
        tmr_sel = bnk; sys_tc = tc; dma_req = 1'b1; dma_ack = 1'b1;
        card_wait_n = (k > 0) ? 1'b0 : 1'b1;
        forever begin
            @(negedge clk);
            guard++;
            if (guard > 20000) break;
            if (!busy && started) break;
            if (busy && !started) begin
                started = 1;
                dma_req = 1'b0; dma_ack = 1'b0; sys_tc = 1'b0;
                if (midwr) begin
                    // R8: mid-transfer write to bank 0 command byte (02h -> 3 clocks)
                    cfg_we = 1'b1; cfg_set = 1'b0; cfg_phase = 2'd1; cfg_wdata = 8'h02;
                end
            end else begin
                cfg_we = 1'b0;
            end
            if (busy && rd_stb_n && !seen_rd) pre++;
            if (!rd_stb_n) begin
                seen_rd = 1;
                rdw++;
                if (k > 0 && rdw == k) card_wait_n = 1'b1;
            end
            if (!oe_n) oew++;
            if (busy && rd_stb_n && seen_rd) post++;
            if (cycle_done) donec++;
        end
        cfg_we = 1'b0;
        card_wait_n = 1'b1;
        chk(req, "setup clocks", pre, es);
        chk(req, "strobe clocks", rdw, ew);
        chk(req, "recovery clocks", post, er);
        chk(req, "oe clocks", oew, eo);
        chk(req, "done pulses", donec, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1", "busy", busy, 0);
        chk("R1", "rd_stb_n", rd_stb_n, 1);
        chk("R1", "oe_n", oe_n, 1);
        chk("R1", "cycle_done", cycle_done, 0);

        // R2: request or acknowledge alone does not start a transfer
        dma_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2", "busy with req only", busy, 0);
        dma_req = 1'b0; dma_ack = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2", "busy with ack only", busy, 0);
        dma_ack = 1'b0;

        // R4: bank 1 resets to 00h everywhere -> 1/1/1, no OE even with TC
        run_cycle(1'b1, 1'b1, 0, 0, 1, 1, 1, 0, "R4");

        // R3 R8: program bank 1 = 02h / 41h / 81h -> 3 / 17 / 69
        cfg_write(1'b1, 2'd0, 8'h02);
        cfg_write(1'b1, 2'd1, 8'h41);
        cfg_write(1'b1, 2'd2, 8'h81);

        // Vector table: R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            run_cycle(VECS[i].bank, VECS[i].tc, int'(VECS[i].k), 0,
                      int'(VECS[i].s), int'(VECS[i].w), int'(VECS[i].r),
                      int'(VECS[i].oe), (VECS[i].k != 0) ? "R6" : "R5");
        end

        // R8: write during transfer leaves the running one at 7 clocks
        run_cycle(1'b0, 1'b1, 0, 1, 2, 7, 4, 5, "R8");
        // R8: phase code 3 is ignored
        cfg_write(1'b0, 2'd3, 8'hFF);
        // R8 R7: next transfer uses the new 3-clock command, OE for 1 clock
        run_cycle(1'b0, 1'b1, 0, 0, 2, 3, 4, 1, "R8");

        // R7: command of 2 clocks gives no OE pulse
        cfg_write(1'b0, 2'd1, 8'h01);
        run_cycle(1'b0, 1'b1, 0, 0, 2, 2, 4, 0, "R7");

        // R3: prescale 2048 on setup (C1h -> 2049 clocks)
        cfg_write(1'b1, 2'd0, 8'hC1);
        run_cycle(1'b1, 1'b0, 0, 0, 2049, 17, 69, 0, "R3");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule